// File: doc/BRIEF.md
# Banked Level Interrupt Controller with Shortcut Mirrors

This block gathers level-sensitive interrupt requests from three banks: eight base sources and two peripheral banks of 32 sources each. Each bank has its own enable mask. Software changes a mask through a pair of registers. Writing ones to the set register turns bits on, and writing ones to the clear register turns them off. A pending word for each bank shows which enabled sources are currently asserted.

The base pending word is the first register a handler reads. It also carries two summary bits, one for each peripheral bank. It carries a set of shortcut bits that copy chosen peripheral sources directly, so the handler can find a common source without a second read. One IRQ output signals that anything is pending. One FIQ output follows a single source picked through a control register.

The register port is synchronous and has no handshake. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `banked_intc`

## Requirements
- R1: Reset clears all three enable masks and the FIQ control register, so every register reads zero and `irq` and `fiq` are low while the sources stay active.
- R2: Each bank has a set register and a clear register. The set register is at byte address 0x18 for the base bank, 0x10 for peripheral bank A and 0x14 for peripheral bank B. The clear register is at 0x24, 0x1C and 0x20 for the same banks. A 1 in a set write turns that mask bit on, a 1 in a clear write turns it off, and 0 bits leave the mask unchanged. Reading either register of a bank returns that bank's current mask.
- R3: The pending word of peripheral bank A is at 0x04 and that of bank B is at 0x08. Each equals the bank's source levels ANDed with its mask. Bits 7:0 of the base pending word at 0x00 hold the masked base sources.
- R4: Bits 14:10 of the base pending word copy the masked bank A sources 7, 9, 10, 18 and 19, lowest bit first. Bits 20:15 copy the masked bank B sources 21, 22, 23, 24, 25 and 30, lowest bit first. Bits 31:21 read zero.
- R5: Bit 8 of the base pending word is set when a masked-in bank A source outside the shortcut set is active. Bit 9 does the same for bank B. A shortcut source alone never sets its bank's summary bit. The summary bits have no mask of their own, so a base-bank clear write cannot hide them.
- R6: Base-bank set and clear writes act only on bits 7:0. They never change whether a shortcut bit can appear. Only the home bank's mask gates a shortcut bit.
- R7: `irq` is high exactly when the base pending word is nonzero.
- R8: The FIQ control register is at 0x0C. Bits 6:0 pick a source: 0–31 select bank A, 32–63 select bank B, 64–71 select base sources 0–7, and 72–127 select nothing. Bit 7 enables FIQ. Bits 31:8 are ignored on write and read as zero.
- R9: When FIQ is enabled, `fiq` follows the raw level of the picked source whether or not that source's mask bit is set. When the mask bit is also set, `irq` and `fiq` are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | AW (6) | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_base | input | 8 | Base bank request levels |
| src_a | input | 32 | Peripheral bank A request levels |
| src_b | input | 32 | Peripheral bank B request levels |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The base pending word is driven from a table of source patterns with every mask open. The patterns include a lone base source, a lone non-shortcut source in each peripheral bank, single and complete shortcut sets, and a mix of a shortcut and a non-shortcut source. Together they separate a mirror bit landing at the wrong position from a shortcut wrongly raising its summary bit. Directed sequences then mask sources through the home bank and through the base bank, which shows whether the shortcut gating and the unmaskable summary bits behave as required. The FIQ selector is walked across all three index ranges and into the unused range, with the IRQ mask both off and on.

// File: rtl/banked_intc.sv
module banked_intc #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [7:0]    src_base,
  input  logic [31:0]   src_a,
  input  logic [31:0]   src_b,
  output logic          irq,
  output logic          fiq
);
  localparam logic [AW-1:0] A_PEND0 = AW'(6'h00);
  localparam logic [AW-1:0] A_PENDA = AW'(6'h04);
  localparam logic [AW-1:0] A_PENDB = AW'(6'h08);
  localparam logic [AW-1:0] A_FCTL  = AW'(6'h0C);
  localparam logic [AW-1:0] A_SETA  = AW'(6'h10);
  localparam logic [AW-1:0] A_SETB  = AW'(6'h14);
  localparam logic [AW-1:0] A_SET0  = AW'(6'h18);
  localparam logic [AW-1:0] A_CLRA  = AW'(6'h1C);
  localparam logic [AW-1:0] A_CLRB  = AW'(6'h20);
  localparam logic [AW-1:0] A_CLR0  = AW'(6'h24);
  localparam logic [31:0] SC_A = (32'd1 << 7) | (32'd1 << 9) | (32'd1 << 10)
                               | (32'd1 << 18) | (32'd1 << 19);
  localparam logic [31:0] SC_B = (32'h1F << 21) | (32'd1 << 30);

  logic [7:0]  mask0;
  logic [31:0] mask_a, mask_b;
  logic [7:0]  fctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask0  <= '0;
      mask_a <= '0;
      mask_b <= '0;
      fctl   <= '0;
    end else if (wr_en) begin
      case (addr)
        A_SET0: mask0  <= mask0  |  wdata[7:0];
        A_CLR0: mask0  <= mask0  & ~wdata[7:0];
        A_SETA: mask_a <= mask_a |  wdata;
        A_CLRA: mask_a <= mask_a & ~wdata;
        A_SETB: mask_b <= mask_b |  wdata;
        A_CLRB: mask_b <= mask_b & ~wdata;
        A_FCTL: fctl   <= wdata[7:0];
        default: ;
      endcase
    end
  end

  logic [7:0]  p0;
  logic [31:0] pa, pb, word0;
  assign p0 = src_base & mask0;
  assign pa = src_a & mask_a;
  assign pb = src_b & mask_b;

  assign word0 = {11'b0,
                  pb[30], pb[25:21],
                  pa[19], pa[18], pa[10], pa[9], pa[7],
                  |(pb & ~SC_B), |(pa & ~SC_A),
                  p0};

  assign irq = |word0;

  logic [6:0] sel;
  logic       sel_lvl;
  assign sel = fctl[6:0];
  always_comb begin
    case (sel[6:5])
      2'd0:    sel_lvl = src_a[sel[4:0]];
      2'd1:    sel_lvl = src_b[sel[4:0]];
      2'd2:    sel_lvl = (sel[4:3] == 2'd0) ? src_base[sel[2:0]] : 1'b0;
      default: sel_lvl = 1'b0;
    endcase
  end
  assign fiq = fctl[7] & sel_lvl;

  always_comb begin
    case (addr)
      A_PEND0:        rdata = word0;
      A_PENDA:        rdata = pa;
      A_PENDB:        rdata = pb;
      A_FCTL:         rdata = {24'b0, fctl};
      A_SET0, A_CLR0: rdata = {24'b0, mask0};
      A_SETA, A_CLRA: rdata = mask_a;
      A_SETB, A_CLRB: rdata = mask_b;
      default:        rdata = '0;
    endcase
  end
endmodule

module banked_intc_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic [7:0]    src_base,
  input logic [31:0]   src_a,
  input logic [31:0]   src_b,
  input logic [31:0]   mask_a,
  input logic [7:0]    fctl,
  input logic          irq,
  input logic          fiq
);
  // R2
  set_bits_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(6'h10)) |=> ((mask_a & $past(wdata)) == $past(wdata)));
  // R2
  clr_bits_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(6'h1C)) |=> ((mask_a & $past(wdata)) == 32'd0));
  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == AW'(6'h10) || addr == AW'(6'h1C))) |=> $stable(mask_a));
  // R9
  fiq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq |-> fctl[7]);
  // R7
  irq_has_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|src_base) || (|src_a) || (|src_b)));
  // R8
  fiq_unused_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fctl[6:0] >= 7'd72) |-> !fiq);
endmodule

bind banked_intc banked_intc_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .src_base(src_base), .src_a(src_a), .src_b(src_b),
  .mask_a(mask_a), .fctl(fctl), .irq(irq), .fiq(fiq));

// File: tb/banked_intc_tb.sv
module banked_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  src_base = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        irq, fiq;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  banked_intc dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_base(src_base), .src_a(src_a),
    .src_b(src_b), .irq(irq), .fiq(fiq));

  // {src_base, src_a, src_b, expected base pending word}
  localparam int NV = 9;
  localparam logic [103:0] VEC [NV] = '{
    {8'h00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {8'h05, 32'h0000_0000, 32'h0000_0000, 32'h0000_0005},
    {8'h00, 32'h0000_0001, 32'h0000_0000, 32'h0000_0100},
    {8'h00, 32'h0000_0080, 32'h0000_0000, 32'h0000_0400},
    {8'h00, 32'h000C_0680, 32'h0000_0000, 32'h0000_7C00},
    {8'h00, 32'h0000_0000, 32'h0020_0000, 32'h0000_8000},
    {8'h00, 32'h0000_0000, 32'h4000_0000, 32'h0010_0000},
    {8'h00, 32'h0000_0000, 32'h0000_0010, 32'h0000_0200},
    {8'h80, 32'h0000_0280, 32'h8000_0000, 32'h0000_0E80}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    src_base = 8'hFF; src_a = '1; src_b = '1;
    repeat (3) @(negedge clk);
    // R1: registers and outputs clear after reset with all sources high
    rd(6'h00, v); check("R1 pend0", v, 0);
    rd(6'h10, v); check("R1 maskA", v, 0);
    rd(6'h14, v); check("R1 maskB", v, 0);
    rd(6'h18, v); check("R1 mask0", v, 0);
    rd(6'h0C, v); check("R1 fctl", v, 0);
    check("R1 irq/fiq", {30'b0, irq, fiq}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: write-one set/clear on bank A
    wr(6'h10, 32'h0000_00F0);
    rd(6'h10, v); check("R2 set", v, 32'hF0);
    wr(6'h10, 32'h0000_0001);
    rd(6'h1C, v); check("R2 set keeps, clear reg reads mask", v, 32'hF1);
    wr(6'h1C, 32'h0000_0030);
    rd(6'h10, v); check("R2 clear", v, 32'hC1);
    // R3: masked peripheral pending
    rd(6'h04, v); check("R3 pendA", v, 32'hC1);
    wr(6'h14, 32'hA500_0003);
    src_b = 32'hFF00_0001;
    rd(6'h08, v); check("R3 pendB", v, 32'hA500_0001);

    // R4 R5 R7: table of source patterns with all masks open
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {src_base, src_a, src_b} = VEC[i][103:32];
      rd(6'h00, v);
      check("R4/R5 pend0 vector", v, VEC[i][31:0]);
      check("R7 irq", {31'b0, irq}, {31'b0, VEC[i][31:0] != 0});
    end

    // R6: base bank writes only touch bits 7:0
    rd(6'h18, v); check("R6 mask0 width", v, 32'hFF);
    wr(6'h24, 32'hFFFF_FF00);
    rd(6'h24, v); check("R6 clear upper bits ignored", v, 32'hFF);
    src_base = 0; src_a = 32'h0000_0081; src_b = 32'h0020_0000;
    wr(6'h20, 32'h0020_0000);
    rd(6'h00, v); check("R6 shortcut gated by home bank", v, 32'h0000_0500);
    // R5: base clear write cannot hide summary bit
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h00, v); check("R5 summary unmaskable", v, 32'h0000_0500);

    // R8 R9: FIQ selection
    src_a = 0; src_b = 0; src_base = 0;
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h0C, 32'hFFFF_FF83);
    rd(6'h0C, v); check("R8 fctl readback", v, 32'h83);
    src_a = 32'h0000_0008;
    #1 check("R9 fiq raw, irq masked", {30'b0, irq, fiq}, 32'b01);
    wr(6'h10, 32'h0000_0008);
    #1 check("R9 both outputs", {30'b0, irq, fiq}, 32'b11);
    wr(6'h0C, 32'h0000_0003);
    #1 check("R8 fiq disabled", {31'b0, fiq}, 0);
    src_b = 32'h0000_0100;
    wr(6'h0C, 32'h0000_00A8);
    #1 check("R8 bank B index 40", {31'b0, fiq}, 1);
    src_base = 8'h04;
    wr(6'h0C, 32'h0000_00C2);
    #1 check("R8 base index 66", {31'b0, fiq}, 1);
    src_base = 8'hFF; src_a = '1; src_b = '1;
    wr(6'h0C, 32'h0000_00E4);
    #1 check("R8 unused index 100", {31'b0, fiq}, 0);

    // R1: mid-run reset
    wr(6'h0C, 32'h0000_0080);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    rd(6'h10, v); check("R1 maskA after reset", v, 0);
    rd(6'h0C, v); check("R1 fctl after reset", v, 0);
    check("R1 outputs after reset", {30'b0, irq, fiq}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule